// File: doc/BRIEF.md
# Integer Carry Flag Unit

This block produces and holds the carry bit of an integer execution unit. It does no arithmetic and no shifting itself. Each cycle it is given an operation code, the two source operands, the result that a separate datapath already computed, and a width select. It then decides what the carry bit must become. Add-type and subtract-type carries are worked out by an unsigned comparison of the result against one operand, not from an adder carry-out. For algebraic right shifts, the carry is set only when a negative source loses at least one 1 bit.

The carry lives in one register inside the block. That register value is also the incoming carry for the extended operations, so it can only ever be 0 or 1. The register loads only on a cycle where the update strobe is high and the code is one the block recognises. The data width `DW` is a parameter with a default of 64. The word size `HW` is `DW/2`, which is 32 by default.

Top module: `carry_flag_unit`

## Requirements
- R1: While reset is low, and after reset until the first accepted update, `ca` is 0.
- R2: Code 0 (add): the new carry is 1 exactly when `res` is unsigned-less-than `lhs`.
- R3: Code 1 (add with carry in): the new carry is 1 when `res` is unsigned-less-than `lhs`, or when the current carry is 1 and `res` equals `lhs`.
- R4: Code 8 (subtract-from with carry in): the new carry is 1 when `res` is unsigned-less-than `rhs`, or when the current carry is 1 and `res` equals `rhs`.
- R5: Codes 7 and 9 (subtract-from carrying and subtract-from immediate): the new carry is 1 exactly when `res` is unsigned-less-than-or-equal to `rhs`.
- R6: Width select for codes 0, 1, 7, 8 and 9. With `wide` = 0, the comparisons use only bits HW-1..0 of `lhs`, `rhs` and `res`. With `wide` = 1, they use all DW bits.
- R7: Code 11 (word shift, immediate amount): the amount is `rhs[log2(HW)-1:0]` and the source is `lhs[HW-1:0]`. The new carry is 1 only when source bit HW-1 is 1 and some source bit below the amount position is 1. `wide` has no effect on shift codes.
- R8: Code 10 (word shift, register amount): the amount is `rhs[log2(DW)-1:0]`, with a range of 0..DW-1. If the amount exceeds HW-1, the new carry equals `lhs[HW-1]`. Otherwise the R7 rule applies.
- R9: Code 13 (doubleword shift, immediate amount): the amount is `rhs[log2(DW)-1:0]` and the source is all of `lhs`. The new carry is 1 only when `lhs[DW-1]` is 1 and some bit below the amount position is 1.
- R10: Code 12 (doubleword shift, register amount): the amount is `rhs[log2(DW):0]`. If the amount exceeds DW-1, the new carry equals `lhs[DW-1]`. Otherwise the R9 rule applies.
- R11: The carry is unchanged when `upd` is 0, and when `upd` is 1 with any code other than 0, 1, 7, 8, 9, 10, 11, 12 or 13.
- R12: An accepted update is visible on `ca` right after the rising clock edge where `upd` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd | input | 1 | Update strobe for the carry register |
| op | input | 4 | Operation code |
| wide | input | 1 | 1 selects full DW compare width, 0 selects HW |
| lhs | input | DW | Left source operand, also the shift source |
| rhs | input | DW | Right source operand, also the shift amount |
| res | input | DW | Result already computed by the datapath |
| ca | output | 1 | Registered carry bit |

## Verification
The properties assume three things about the inputs. The incoming carry is the block's own register, so it is always 0 or 1. `op`, `rhs`, `lhs`, `res` and `wide` hold known values on any cycle where `upd` is high. Operands are sampled only at the rising edge. The stimulus keeps to these assumptions: it changes every input on the falling edge and drives only defined values. It sets the prior carry for the extended codes through an ordinary add update, never by forcing the register. The sweeps run with `DW` = 8. This makes the word shifts have a 4-bit source and lets the register-amount codes cover every out-of-range amount.

// File: rtl/carry_flag_unit.sv
module carry_flag_unit #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  logic [3:0]    op,
  input  logic          wide,
  input  logic [DW-1:0] lhs,
  input  logic [DW-1:0] rhs,
  input  logic [DW-1:0] res,
  output logic          ca
);
  localparam int HW  = DW / 2;
  localparam int AW  = $clog2(DW);
  localparam int HAW = $clog2(HW);

  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_ADDX = 4'd1;
  localparam logic [3:0] OP_SUBC = 4'd7;
  localparam logic [3:0] OP_SUBX = 4'd8;
  localparam logic [3:0] OP_SUBI = 4'd9;
  localparam logic [3:0] OP_WSR  = 4'd10;
  localparam logic [3:0] OP_WSI  = 4'd11;
  localparam logic [3:0] OP_DSR  = 4'd12;
  localparam logic [3:0] OP_DSI  = 4'd13;

  logic [DW-1:0] lm, rm, sm;
  assign lm = wide ? lhs : {{HW{1'b0}}, lhs[HW-1:0]};
  assign rm = wide ? rhs : {{HW{1'b0}}, rhs[HW-1:0]};
  assign sm = wide ? res : {{HW{1'b0}}, res[HW-1:0]};

  logic lt_l, eq_l, lt_r, eq_r;
  assign lt_l = sm < lm;
  assign eq_l = sm == lm;
  assign lt_r = sm < rm;
  assign eq_r = sm == rm;

  logic          wneg, wlost, wimm, wreg;
  logic [HW-1:0] wkeep;
  assign wneg  = lhs[HW-1];
  assign wkeep = {HW{1'b1}} << rhs[HAW-1:0];
  assign wlost = |(lhs[HW-1:0] & ~wkeep);
  assign wimm  = wneg & wlost;
  assign wreg  = rhs[AW-1] ? wneg : wimm;

  logic          dneg, dlost, dimm, dreg;
  logic [DW-1:0] dkeep;
  assign dneg  = lhs[DW-1];
  assign dkeep = {DW{1'b1}} << rhs[AW-1:0];
  assign dlost = |(lhs & ~dkeep);
  assign dimm  = dneg & dlost;
  assign dreg  = rhs[AW] ? dneg : dimm;

  logic hit, nxt;
  always_comb begin
    hit = 1'b1;
    nxt = ca;
    case (op)
      OP_ADD:           nxt = lt_l;
      OP_ADDX:          nxt = lt_l | (ca & eq_l);
      OP_SUBX:          nxt = lt_r | (ca & eq_r);
      OP_SUBC, OP_SUBI: nxt = lt_r | eq_r;
      OP_WSR:           nxt = wreg;
      OP_WSI:           nxt = wimm;
      OP_DSR:           nxt = dreg;
      OP_DSI:           nxt = dimm;
      default:          hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ca <= 1'b0;
    else if (upd && hit) ca <= nxt;
  end
endmodule

// File: rtl/carry_flag_unit_chk.sv
module carry_flag_unit_chk #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          upd,
  input logic [3:0]    op,
  input logic          wide,
  input logic [DW-1:0] lhs,
  input logic [DW-1:0] rhs,
  input logic [DW-1:0] res,
  input logic          ca
);
  localparam int HW = DW / 2;
  localparam int AW = $clog2(DW);

  logic known_op;
  assign known_op = (op <= 4'd1) || (op >= 4'd7 && op <= 4'd13);

  p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(ca));

  p_hold_unknown_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !known_op) |=> $stable(ca));

  p_add_eq_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && op == 4'd0 && wide && res == lhs) |=> !ca);

  p_subc_eq_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && (op == 4'd7 || op == 4'd9) && wide && res == rhs) |=> ca);

  p_addx_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && op == 4'd1 && wide && res == lhs) |=> $stable(ca));

  p_wshift_pos_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && (op == 4'd10 || op == 4'd11) && !lhs[HW-1]) |=> !ca);

  p_wshift_big_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && op == 4'd10 && rhs[AW-1]) |=> ca == $past(lhs[HW-1]));

  p_dshift_big_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && op == 4'd12 && rhs[AW]) |=> ca == $past(lhs[DW-1]));

  p_dshift_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && op == 4'd13 && rhs[AW-1:0] == '0) |=> !ca);
endmodule

bind carry_flag_unit carry_flag_unit_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .upd(upd), .op(op), .wide(wide),
  .lhs(lhs), .rhs(rhs), .res(res), .ca(ca)
);

// File: tb/test_carry_flag_unit.sv
`timescale 1ns/1ps
module test_carry_flag_unit;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          upd = 1'b0;
  logic [3:0]    op = '0;
  logic          wide = 1'b0;
  logic [DW-1:0] lhs = '0, rhs = '0, res = '0;
  logic          ca;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  carry_flag_unit #(.DW(DW)) i_carry_flag_unit (
    .clk(clk), .rst_n(rst_n), .upd(upd), .op(op), .wide(wide),
    .lhs(lhs), .rhs(rhs), .res(res), .ca(ca)
  );

  task automatic chk(input string req, input logic exp);
    checks++;
    if (ca !== exp) begin
      fails++;
      $display("FAIL %s: ca=%b expected %b (op=%0d wide=%b lhs=%h rhs=%h res=%h)",
               req, ca, exp, op, wide, lhs, rhs, res);
    end
  endtask

  task automatic step(input logic u, input int o, input logic w,
                      input int l, input int r, input int s);
    upd = u; op = 4'(o); wide = w;
    lhs = DW'(l); rhs = DW'(r); res = DW'(s);
    @(negedge clk);
  endtask

  task automatic set_ca(input logic b);
    step(1'b1, 0, 1'b1, 8'h10, 0, b ? 8'h0f : 8'h10);
  endtask

  function automatic logic lost(input int v, input int amt);
    logic any = 1'b0;
    for (int i = 0; i < amt; i++) if (v[i]) any = 1'b1;
    return any;
  endfunction

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int ops [5] = '{0, 1, 7, 8, 9};
    @(negedge clk);
    chk("R1 in reset", 1'b0);
    step(1'b1, 0, 1'b1, 8'h80, 0, 8'h01);
    chk("R1 strobe ignored in reset", 1'b0);
    rst_n = 1'b1;
    step(1'b0, 0, 1'b1, 8'h80, 0, 8'h01);
    chk("R1 after reset", 1'b0);

    set_ca(1'b1);
    chk("R12 add sets carry", 1'b1);
    step(1'b0, 0, 1'b1, 8'h01, 0, 8'h05);
    chk("R11 strobe low keeps carry", 1'b1);
    for (int o = 2; o <= 15; o++) begin
      if (o >= 7 && o <= 13) continue;
      step(1'b1, o, 1'b1, 8'h01, 8'hff, 8'h05);
      chk("R11 unknown code keeps carry", 1'b1);
    end
    set_ca(1'b0);
    for (int o = 2; o <= 6; o++) begin
      step(1'b1, o, 1'b1, 8'hff, 8'h00, 8'h00);
      chk("R11 unknown code keeps clear", 1'b0);
    end

    for (int w = 0; w < 2; w++)
      foreach (ops[k])
        for (int oc = 0; oc < 2; oc++) begin
          if (oc == 1 && ops[k] != 1 && ops[k] != 8) continue;
          for (int a = 0; a < 256; a += 5)
            for (int s = 0; s < 256; s += 5) begin
              int l, r, lm, rm, sm;
              logic e;
              string tag;
              l = (ops[k] == 0 || ops[k] == 1) ? a : (a ^ 8'h5a);
              r = (ops[k] == 0 || ops[k] == 1) ? (a ^ 8'ha5) : a;
              lm = w ? l : (l & 15);
              rm = w ? r : (r & 15);
              sm = w ? s : (s & 15);
              case (ops[k])
                0: begin e = sm < lm; tag = "R2 add"; end
                1: begin e = (sm < lm) || (oc == 1 && sm == lm); tag = "R3 add-ext"; end
                8: begin e = (sm < rm) || (oc == 1 && sm == rm); tag = "R4 sub-ext"; end
                default: begin e = sm <= rm; tag = "R5 sub-carrying"; end
              endcase
              if (!w) tag = {tag, " R6 narrow"};
              if (ops[k] == 1 || ops[k] == 8) set_ca(logic'(oc));
              step(1'b1, ops[k], logic'(w), l, r, s);
              chk(tag, e);
            end
        end

    for (int o = 10; o <= 13; o++)
      for (int l = 0; l < 256; l++)
        for (int r = 0; r < 16; r++) begin
          logic e, sw, sd;
          string tag;
          sw = l[3];
          sd = l[7];
          case (o)
            11: begin e = sw && lost(l & 15, r % 4); tag = "R7 word imm"; end
            10: begin e = ((r % 8) > 3) ? sw : (sw && lost(l & 15, r % 8)); tag = "R8 word reg"; end
            13: begin e = sd && lost(l, r % 8); tag = "R9 dword imm"; end
            default: begin e = (r > 7) ? sd : (sd && lost(l, r)); tag = "R10 dword reg"; end
          endcase
          step(1'b1, o, logic'((l + r) % 2), l, r | ((l & 1) << 5), 8'h00);
          chk(tag, e);
        end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule